// File: doc/BRIEF.md
# Four-Times Linear Interpolation Upsampler

This block takes a stream of 12-bit converter samples that arrive at a base rate Fs. It turns them into a 14-bit stream at four times that rate. Two registers hold the most recent pair of real samples: the older one is A and the newer one is E. The four quarter-step points between them are computed in parallel from weighted sums, each scaled by four so that the two extra low bits carry the fraction. A two-bit phase counter, advanced by a 4×Fs clock-enable tick, selects which point leaves the block on each tick.

Each point is `(4-p)*A + p*E`, where p is the phase (0 to 3). Phase 0 is therefore A with two zero bits appended. Phase 2 is the 13-bit sum A+E with one zero bit appended. Phases 1 and 3 are 3A+E and A+3E. When a new real sample arrives, the held pair shifts and the phase restarts at 0. The output stays silent until two real samples have been held since reset.

Top module: `quad_interp_upsampler`

## Requirements
- R1: After reset, outValid is 0, outData is 0, the phase is 0 and no real sample counts as held.
- R2: In a cycle with sampleValid high, sampleIn is stored as the newer sample E, and the previous E moves into the older register A.
- R3: outValid stays 0 on every tick until two real samples have been stored since reset.
- R4: A tick4x cycle in which two samples are held makes outValid high for exactly the next cycle, with outData set to the point of the phase current at that tick. Without a tick, outValid is 0.
- R5: Phase 0 (binary 00) emits 4*A, that is A followed by two zero bits.
- R6: Phase 1 (binary 01) emits 3*A + E.
- R7: Phase 2 (binary 10) emits 2*(A + E), that is the 13-bit sum A+E followed by one zero bit.
- R8: Phase 3 (binary 11) emits A + 3*E.
- R9: Each tick4x cycle without sampleValid advances the phase by one, and phase 3 wraps to phase 0.
- R10: A sampleValid cycle sets the phase to 0. If a tick falls in the same cycle, the emitted point uses the phase and samples held before that edge.
- R11: Full-scale inputs (A = E = 4095) give 16380 on every phase, with no wrap-around in the 14-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 12 | Real sample from the converter |
| sampleValid | input | 1 | One-cycle strobe: sampleIn holds a new real sample |
| tick4x | input | 1 | Clock-enable at four times the sample rate |
| outData | output | 14 | Interpolated sample, two fractional bits |
| outValid | output | 1 | One-cycle strobe marking a new outData value |

## Verification
The assertions assume that sampleValid and tick4x are single-cycle strobes sampled on the rising edge, and that reset is held for at least one edge. The assertions on phase advance and clearing also rely on those two strobes never being X after reset. The stimulus drives every input only on the falling edge. It keeps the strobes high for exactly one cycle. Across the random periods it varies the number of ticks from one to six, so the phase counter wraps, and it sometimes lands a tick in the same cycle as a new sample.

// File: rtl/quad_interp_pkg.sv
package quad_interp_pkg;
  typedef struct packed {
    logic load;
    logic emit;
  } ctrlStrobes_t;
endpackage

// File: rtl/quad_interp_ctrl.sv
module quad_interp_ctrl
  import quad_interp_pkg::*;
#(
  parameter int FRAC_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              tick4x,
  output ctrlStrobes_t      strobes,
  output logic [FRAC_W-1:0] phase
);
  logic [1:0] fillCnt;
  logic       filled;

  assign filled = (fillCnt == 2'd2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (sampleValid && !filled) begin
      fillCnt <= fillCnt + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (sampleValid) begin
      phase <= '0;
    end else if (tick4x) begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    strobes.load = sampleValid;
    strobes.emit = tick4x && filled;
  end

  // R10: a new real sample restarts the phase
  assert_phase_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> (phase == '0));

  // R9: a plain tick advances the phase by one, with wrap
  assert_phase_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tick4x && !sampleValid) |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/quad_interp_datapath.sv
module quad_interp_datapath
  import quad_interp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int FRAC_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [DATA_W-1:0]        sampleIn,
  input  ctrlStrobes_t             strobes,
  input  logic [FRAC_W-1:0]        phase,
  output logic [DATA_W+FRAC_W-1:0] outData,
  output logic                     outValid
);
  localparam int OUT_W = DATA_W + FRAC_W;
  localparam int STEPS = 1 << FRAC_W;

  logic [DATA_W-1:0] older;
  logic [DATA_W-1:0] newer;
  logic [OUT_W-1:0]  olderWide;
  logic [OUT_W-1:0]  newerWide;
  logic [OUT_W-1:0]  points [STEPS];

  assign olderWide = {{FRAC_W{1'b0}}, older};
  assign newerWide = {{FRAC_W{1'b0}}, newer};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      older <= '0;
      newer <= '0;
    end else if (strobes.load) begin
      older <= newer;
      newer <= sampleIn;
    end
  end

  for (genvar k = 0; k < STEPS; k++) begin : gPoint
    localparam logic [OUT_W-1:0] W_OLD = OUT_W'(STEPS - k);
    localparam logic [OUT_W-1:0] W_NEW = OUT_W'(k);
    assign points[k] = W_OLD * olderWide + W_NEW * newerWide;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobes.emit;
      if (strobes.emit) outData <= points[phase];
    end
  end

  // R2: the previous newer sample shifts into the older register
  assert_shift_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (older == $past(newer)));

  // R5: phase zero output carries zero fractional bits
  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.emit && phase == '0) |=> (outData[FRAC_W-1:0] == '0));
endmodule

// File: rtl/quad_interp_upsampler.sv
module quad_interp_upsampler
  import quad_interp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int FRAC_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [DATA_W-1:0]        sampleIn,
  input  logic                     sampleValid,
  input  logic                     tick4x,
  output logic [DATA_W+FRAC_W-1:0] outData,
  output logic                     outValid
);
  ctrlStrobes_t      strobes;
  logic [FRAC_W-1:0] phase;

  quad_interp_ctrl #(.FRAC_W(FRAC_W)) ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .tick4x(tick4x),
    .strobes(strobes), .phase(phase)
  );

  quad_interp_datapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) datapath (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .strobes(strobes),
    .phase(phase), .outData(outData), .outValid(outValid)
  );

  // R4: every output strobe follows a tick on the previous edge
  assert_valid_after_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(tick4x));
endmodule

// File: tb/quad_interp_upsampler_test.sv
`timescale 1ns/1ps
module quad_interp_upsampler_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] sampleIn = '0;
  logic        sampleValid = 1'b0;
  logic        tick4x = 1'b0;
  logic [13:0] outData;
  logic        outValid;

  int total = 0;
  int bad = 0;

  logic [11:0] mOld = '0, mNew = '0;
  int          mCnt = 0;
  int          mPh = 0;

  always #2.5 clk = ~clk;

  quad_interp_upsampler uut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .tick4x(tick4x), .outData(outData), .outValid(outValid)
  );

  function automatic int expPoint(int a, int e, int ph);
    return (4 - ph) * a + ph * e;
  endfunction

  function automatic string phaseReq(int ph);
    case (ph)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, check at next falling edge
  task automatic step(bit doSample, logic [11:0] val, bit doTick, string tag);
    bit expV;
    int expD;
    int ph;
    sampleValid = doSample;
    sampleIn    = val;
    tick4x      = doTick;
    ph   = mPh;
    expV = doTick && (mCnt == 2);
    expD = expPoint(mOld, mNew, mPh);
    if (doTick) mPh = (mPh + 1) % 4;
    if (doSample) begin
      mOld = mNew; mNew = val;
      if (mCnt < 2) mCnt++;
      mPh = 0;
    end
    @(negedge clk);
    sampleValid = 1'b0;
    tick4x      = 1'b0;
    check({tag, " valid R4"}, outValid, expV);
    if (expV) check({tag, " data ", phaseReq(ph)}, outData, expD);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1 valid", outValid, 0);
    check("R1 data", outData, 0);
    // R3: tick with nothing held, then with one sample
    step(0, 12'd0, 1, "R3 empty");
    step(1, 12'd100, 0, "R2 first");
    step(0, 12'd0, 1, "R3 one");
    step(0, 12'd0, 0, "R4 idle");
    // R2, R5-R8: second sample makes A=100, E=200
    step(1, 12'd200, 0, "R2 second");
    for (int i = 0; i < 4; i++) step(0, 12'd0, 1, "R2 R5-R8 seq");
    // R9: wrap beyond phase 3 gives 4A again
    step(0, 12'd0, 1, "R9 wrap");
    step(0, 12'd0, 1, "R9 wrap2");
    // R10: sample mid-phase restarts at phase 0; same-edge tick uses old state
    step(1, 12'd7, 1, "R10 same-edge");
    step(0, 12'd0, 1, "R10 restart");
    step(0, 12'd0, 1, "R10 next");
    // R11: full scale
    step(1, 12'hFFF, 0, "R11 load1");
    step(1, 12'hFFF, 0, "R11 load2");
    for (int i = 0; i < 4; i++) step(0, 12'd0, 1, "R11 full");
    // descending edge: A=4095, E=0
    step(1, 12'd0, 0, "R6 down load");
    for (int i = 0; i < 4; i++) step(0, 12'd0, 1, "R6 R8 down");
    // random periods
    for (int p = 0; p < 300; p++) begin
      int nTicks;
      logic [11:0] v;
      v = 12'($urandom_range(0, 4095));
      nTicks = $urandom_range(1, 6);
      step(1, v, ($urandom_range(0, 7) == 0), "R10 rand load");
      for (int t = 0; t < nTicks; t++) begin
        step(0, 12'd0, 1, "R9 rand");
        if ($urandom_range(0, 3) == 0) step(0, 12'd0, 0, "R4 rand gap");
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule